// File: doc/BRIEF.md
# Single-Bit NAND Chunk ECC Checker and Fixer

This block judges one 512-byte NAND data chunk after it has been read back. It takes two 24-bit Hamming-style codes. The first is the code kept in the spare area. The second is the code just produced over the data. The second one arrives as the raw 32-bit parity word of a hardware parity accumulator. A packing stage turns that word into the same 24-bit form that is written to the spare area, and also offers it as an output for the write path.

Each 24-bit code has two 12-bit halves: one holds the parity bits, the other the complementary parity bits. The block XORs the stored code with the computed code, which gives a difference word. It then sorts the read into one of four results: clean, one data bit repaired, a fault confined to the ECC bytes, or uncorrectable. When a single data bit has flipped, the difference word gives the byte and the bit directly. The block then emits a byte address, an 8-bit XOR mask and a one-cycle write strobe. A buffer read-modify-write port applies these to fix the data. The buffer itself lies outside the block.

Top module: `nand_ecc1_fix`

## Requirements
- R1: While reset is held, and after it is released until the first start, `done` and `fix_we` are 0 and `status` is 0 (clean).
- R2: `calc_code` is the bitwise inverse of {raw[27:16], raw[11:0]}. An all-zero raw word therefore packs to 24'hFFFFFF. Byte 0 of the stored code sits in `stored_code[7:0]`, byte 1 in [15:8] and byte 2 in [23:16].
- R3: When the difference word (stored XOR computed) is zero, `status` is 0 (clean) and `fix_we` stays 0.
- R4: When the difference's low 12 bits XOR its high 12 bits give 12'hFFF and the byte offset diff[23:15] is below CHUNK_BYTES, `status` is 1 (corrected). In that case `fix_we` pulses, `fix_addr` equals diff[23:15], and `fix_mask` has only bit diff[14:12] set.
- R5: When the halves are complementary but diff[23:15] is not below CHUNK_BYTES, `status` is 3 (uncorrectable) and `fix_we` stays 0.
- R6: When the difference has exactly one bit set, `status` is 2 (fault in ECC bytes only) and `fix_we` stays 0.
- R7: Any other nonzero difference gives `status` 3 (uncorrectable) and `fix_we` stays 0.
- R8: Results appear in the clock cycle after `start` is sampled high. `done` and `fix_we` are single-cycle pulses. `status`, `fix_addr` and `fix_mask` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate the present codes on this edge |
| stored_code | input | 24 | Code read from spare area, byte 0 in bits 7:0 |
| raw_parity | input | 32 | Raw parity word from the data accumulator |
| calc_code | output | 24 | Packed, inverted code computed from raw_parity |
| done | output | 1 | One-cycle result-valid pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 ECC-only, 3 uncorrectable |
| fix_addr | output | 9 | Byte offset of the data bit to flip |
| fix_mask | output | 8 | XOR mask for that byte |
| fix_we | output | 1 | One-cycle strobe that applies the fix |

## Verification
A wrong classification shows up in `status` in the very cycle after `start`. A wrong packing shows up in `calc_code` as soon as the raw word changes, because that path has no register. A decoding fault, such as a swapped bit field or an inverted half, produces a wrong `fix_addr` or a mask that is not one-hot within that same cycle. A missing or repeated strobe would corrupt the buffer, and it is exposed by checking `fix_we` in the cycle after each result.

// File: rtl/nand_ecc1_pkg.sv
package nand_ecc1_pkg;
   typedef enum logic [1:0] {
      ST_CLEAN     = 2'd0,
      ST_FIXED     = 2'd1,
      ST_CODE_ONLY = 2'd2,
      ST_UNCORR    = 2'd3
   } ecc1_status_e;
endpackage

// File: rtl/ecc1_pack.sv
// Turns a raw parity word (two lanes) into the stored code format.
module ecc1_pack #(
   parameter int LANE_W = 16,
   parameter int HALF_W = 12,
   parameter bit INVERT = 1'b1,
   localparam int RAW_W  = 2 * LANE_W,
   localparam int CODE_W = 2 * HALF_W
) (
   input  logic [RAW_W-1:0]  raw,
   output logic [CODE_W-1:0] code
);
   if (HALF_W > LANE_W) begin : g_bad_lane
      $error("ecc1_pack: HALF_W must not exceed LANE_W");
   end

   logic [CODE_W-1:0] packed_w;
   assign packed_w = {raw[LANE_W+HALF_W-1:LANE_W], raw[HALF_W-1:0]};

   if (INVERT) begin : g_inv
      assign code = ~packed_w;
   end else begin : g_plain
      assign code = packed_w;
   end
endmodule

// File: rtl/ecc1_classify.sv
// Sorts a difference word into one of four outcomes.
module ecc1_classify
   import nand_ecc1_pkg::*;
#(
   parameter int HALF_W      = 12,
   parameter int CHUNK_BYTES = 512,
   localparam int CODE_W = 2 * HALF_W,
   localparam int OFS_W  = HALF_W - 3
) (
   input  logic [CODE_W-1:0] diff,
   output ecc1_status_e      verdict,
   output logic [OFS_W-1:0]  byte_ofs,
   output logic [2:0]        bit_ofs
);
   logic [HALF_W-1:0] lo_half, hi_half;
   logic              halves_compl, one_hot, in_range;

   assign lo_half      = diff[HALF_W-1:0];
   assign hi_half      = diff[CODE_W-1:HALF_W];
   assign halves_compl = ((lo_half ^ hi_half) == {HALF_W{1'b1}});
   assign one_hot      = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
   assign byte_ofs     = diff[CODE_W-1:HALF_W+3];
   assign bit_ofs      = diff[HALF_W+2:HALF_W];
   assign in_range     = (32'(byte_ofs) < CHUNK_BYTES);

   always_comb begin
      if (diff == '0)                    verdict = ST_CLEAN;
      else if (halves_compl && in_range) verdict = ST_FIXED;
      else if (halves_compl)             verdict = ST_UNCORR;
      else if (one_hot)                  verdict = ST_CODE_ONLY;
      else                               verdict = ST_UNCORR;
   end
endmodule

// File: rtl/ecc1_maskgen.sv
// One-hot byte mask from a bit index.
module ecc1_maskgen #(
   parameter int IDX_W = 3,
   localparam int MASK_W = 1 << IDX_W
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [MASK_W-1:0] mask
);
   for (genvar i = 0; i < MASK_W; i++) begin : g_bit
      assign mask[i] = (idx == IDX_W'(i));
   end
endmodule

// File: rtl/nand_ecc1_fix.sv
module nand_ecc1_fix
   import nand_ecc1_pkg::*;
#(
   parameter int LANE_W      = 16,
   parameter int HALF_W      = 12,
   parameter int CHUNK_BYTES = 512,
   localparam int RAW_W  = 2 * LANE_W,
   localparam int CODE_W = 2 * HALF_W,
   localparam int OFS_W  = HALF_W - 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CODE_W-1:0] stored_code,
   input  logic [RAW_W-1:0]  raw_parity,
   output logic [CODE_W-1:0] calc_code,
   output logic              done,
   output logic [1:0]        status,
   output logic [OFS_W-1:0]  fix_addr,
   output logic [7:0]        fix_mask,
   output logic              fix_we
);
   if (CHUNK_BYTES < 1 || CHUNK_BYTES > (1 << OFS_W)) begin : g_bad_chunk
      $error("nand_ecc1_fix: CHUNK_BYTES out of range for HALF_W");
   end
   if (HALF_W < 4) begin : g_bad_half
      $error("nand_ecc1_fix: HALF_W too small");
   end

   logic [CODE_W-1:0] diff_w;
   ecc1_status_e      verdict_w;
   logic [OFS_W-1:0]  byte_w;
   logic [2:0]        bit_w;
   logic [7:0]        mask_w;

   ecc1_pack #(.LANE_W(LANE_W), .HALF_W(HALF_W), .INVERT(1'b1)) u_pack (
      .raw  (raw_parity),
      .code (calc_code)
   );

   assign diff_w = stored_code ^ calc_code;

   ecc1_classify #(.HALF_W(HALF_W), .CHUNK_BYTES(CHUNK_BYTES)) u_cls (
      .diff     (diff_w),
      .verdict  (verdict_w),
      .byte_ofs (byte_w),
      .bit_ofs  (bit_w)
   );

   ecc1_maskgen #(.IDX_W(3)) u_mask (
      .idx  (bit_w),
      .mask (mask_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         fix_we   <= 1'b0;
         status   <= ST_CLEAN;
         fix_addr <= '0;
         fix_mask <= '0;
      end else begin
         done   <= start;
         fix_we <= start && (verdict_w == ST_FIXED);
         if (start) begin
            status   <= verdict_w;
            fix_addr <= byte_w;
            fix_mask <= (verdict_w == ST_FIXED) ? mask_w : 8'h00;
         end
      end
   end
endmodule

// File: rtl/nand_ecc1_fix_chk.sv
module nand_ecc1_fix_chk #(
   parameter int CHUNK_BYTES = 512,
   parameter int CODE_W      = 24,
   parameter int OFS_W       = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CODE_W-1:0] stored_code,
   input logic [CODE_W-1:0] calc_code,
   input logic              done,
   input logic [1:0]        status,
   input logic [OFS_W-1:0]  fix_addr,
   input logic [7:0]        fix_mask,
   input logic              fix_we
);
   // R4
   we_only_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fix_we |-> (status == 2'd1 && done));
   // R4
   mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fix_we |-> ($countones(fix_mask) == 1));
   // R5
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fix_we |-> (32'(fix_addr) < CHUNK_BYTES));
   // R3
   clean_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && stored_code == calc_code) |=> (done && status == 2'd0 && !fix_we));
   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (!done && !fix_we && $stable(status) && $stable(fix_addr)));
endmodule

bind nand_ecc1_fix nand_ecc1_fix_chk #(
   .CHUNK_BYTES(CHUNK_BYTES), .CODE_W(CODE_W), .OFS_W(OFS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .stored_code(stored_code),
   .calc_code(calc_code), .done(done), .status(status), .fix_addr(fix_addr),
   .fix_mask(fix_mask), .fix_we(fix_we)
);

// File: tb/nand_ecc1_fix_test.sv
module nand_ecc1_fix_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] stored = '0;
   logic [31:0] raw = '0;
   logic [23:0] calc_a, calc_b;
   logic        done_a, done_b, we_a, we_b;
   logic [1:0]  st_a, st_b;
   logic [8:0]  addr_a, addr_b;
   logic [7:0]  mask_a, mask_b;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   nand_ecc1_fix uut (
      .clk(clk), .rst_n(rst_n), .start(start), .stored_code(stored),
      .raw_parity(raw), .calc_code(calc_a), .done(done_a), .status(st_a),
      .fix_addr(addr_a), .fix_mask(mask_a), .fix_we(we_a)
   );

   nand_ecc1_fix #(.CHUNK_BYTES(256)) uut_small (
      .clk(clk), .rst_n(rst_n), .start(start), .stored_code(stored),
      .raw_parity(raw), .calc_code(calc_b), .done(done_b), .status(st_b),
      .fix_addr(addr_b), .fix_mask(mask_b), .fix_we(we_b)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Reference: behavioural model of the requirements
   function automatic logic [23:0] ref_pack(input logic [31:0] r);
      logic [23:0] c;
      for (int i = 0; i < 12; i++) begin
         c[i]      = ~r[i];
         c[i + 12] = ~r[i + 16];
      end
      return c;
   endfunction

   function automatic int ref_status(input logic [23:0] d, input int chunk);
      int ones = 0;
      bit compl = 1;
      for (int i = 0; i < 24; i++) ones += d[i];
      for (int i = 0; i < 12; i++) if (d[i] == d[i + 12]) compl = 0;
      if (ones == 0) return 0;
      if (compl) return ((d >> 15) < chunk) ? 1 : 3;
      if (ones == 1) return 2;
      return 3;
   endfunction

   // Apply one evaluation; diff chosen by caller, stored derived from raw.
   task automatic run_case(input string req, input logic [31:0] r, input logic [23:0] d);
      int es_a, es_b;
      @(negedge clk);
      raw    = r;
      stored = ref_pack(r) ^ d;
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
      es_a = ref_status(d, 512);
      es_b = ref_status(d, 256);
      chk(req, "done", done_a, 1);
      chk(req, "status", st_a, es_a);
      chk(req, "fix_we", we_a, es_a == 1);
      chk(req, "small status", st_b, es_b);
      chk(req, "small fix_we", we_b, es_b == 1);
      if (es_a == 1) begin
         chk(req, "fix_addr", addr_a, d >> 15);
         chk(req, "fix_mask", mask_a, 8'h01 << ((d >> 12) & 7));
      end
      // R8: next cycle the pulses are gone and results hold
      @(negedge clk);
      chk("R8", "done drop", done_a, 0);
      chk("R8", "we drop", we_a, 0);
      chk("R8", "status hold", st_a, es_a);
   endtask

   function automatic logic [23:0] single_err(input int byte_i, input int bit_i);
      logic [11:0] h;
      h = 12'((byte_i << 3) | bit_i);
      return {h, ~h};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk("R1", "done in reset", done_a, 0);
      chk("R1", "we in reset", we_a, 0);
      chk("R1", "status in reset", st_a, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "status after reset", st_a, 0);
      chk("R1", "done after reset", done_a, 0);

      // R2 packing
      raw = 32'h0000_0000; #1 chk("R2", "pack zero", calc_a, 24'hFFFFFF);
      raw = 32'hFFFF_FFFF; #1 chk("R2", "pack ones", calc_a, 24'h000000);
      raw = 32'h1234_5678; #1 chk("R2", "pack mixed", calc_a, 24'hDCB987);
      raw = 32'hF000_F000; #1 chk("R2", "pack unused bits", calc_a, 24'hFFFFFF);

      // R3 clean
      run_case("R3", 32'h0ABC_0DEF, 24'h0);
      run_case("R3", 32'hFFFF_FFFF, 24'h0);
      // R4 single data bit
      run_case("R4", 32'h0123_0456, single_err(0, 0));
      run_case("R4", 32'h0FED_0CBA, single_err(511, 7));
      run_case("R4", 32'h0555_0AAA, single_err(100, 5));
      // R5 out-of-chunk offset (small instance), in-range on default
      run_case("R5", 32'h0321_0654, single_err(300, 3));
      run_case("R5", 32'h0000_0000, single_err(256, 0));
      // R6 single bit in code
      run_case("R6", 32'h0777_0111, 24'h000001);
      run_case("R6", 32'h0777_0111, 24'h800000);
      run_case("R6", 32'h0222_0333, 24'h001000);
      // R7 others
      run_case("R7", 32'h0444_0888, 24'h000003);
      run_case("R7", 32'h0444_0888, 24'h123456);
      run_case("R7", 32'h0444_0888, 24'hFFFFFF);

      // R8 long idle: results stay put
      repeat (5) @(negedge clk);
      chk("R8", "idle status", st_a, 3);
      chk("R8", "idle done", done_a, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule